// File: doc/BRIEF.md
# Recursive Block-Tiled Address Mapper

This block turns a coordinate on a block-tiled surface into a byte offset in memory. The column is given in bytes and the row in lines. The surface is cut into tiles that are 64 bytes wide. The tile height can be selected from five sizes. Tiles are stored one after another in row-major order, and the row length in tiles is supplied with every request.

Inside a tile, the bytes follow a nested layout with three levels:
- strips of 64x8 bytes;
- quads of 32x4 bytes;
- cells of 8x2 bytes.

Any level that is taller than the tile is dropped.

A second stage can scramble the memory at a coarse grain. It works on aligned memory blocks in groups of twelve. Each block inside a group moves by a fixed signed number of block positions. Two patterns are available, one with a block size of 8 KiB and one with 16 KiB. This stage runs only when the page-attribute reorder bit is set for the request.

Requests are accepted one per cycle with a valid strobe. Each result appears two clock edges later, also with a valid strobe.

Top module: `tiled_addr_mapper`

## Requirements
- R1: While reset is high, and after reset until the first result, `out_valid` is 0 and `out_offset` is 0.
- R2: A request accepted at clock edge N gives `out_valid` high after edge N+2. A cycle with no request gives no result. Back-to-back requests come out back-to-back, in order.
- R3: `in_h_sel` sets the tile height H: 0 gives 4 rows, 1 gives 8, 2 gives 16, 3 gives 32, and 4 gives 64. The values 5 to 7 behave as 4, so H is 64.
- R4: The tile start is ((y / H) * pitch + x / 64) * 64 * H bytes.
- R5: Let ly = y mod H. The offset inside the tile is the sum of four terms:
  - (ly/8) * 512;
  - ((ly mod 8)/4 * 2 + (x mod 64)/32) * 128;
  - ((ly mod 4)/2 * 4 + (x mod 32)/8) * 16;
  - (ly mod 2) * 8 + x mod 8.
- R6: When H is 4, the 64x8 level is skipped. Rows 0 to 3 of a tile then hold two 32x4 quads side by side, and the next tile row starts after 256 bytes.
- R7: Reordering happens only when `in_reorder_flag` is 1. This bit corresponds to page-attribute mask 0x0800.
- R8: With `in_variant` = 0 and reordering on, the block size is 8192 bytes. Let b be the block number. Block b moves to b + P[b mod 12], where P = +1 -1 +1 -1 +1 -1 +2 +3 -2 +2 -3 -2, indexed from 0.
- R9: With `in_variant` = 1 and reordering on, the block size is 16384 bytes, and P = +1 -1 +2 +3 -2 +2 -3 -2 +1 -1 +1 -1.
- R10: Reordering keeps the byte position inside the block. The low 13 bits stay unchanged for variant 0, and the low 14 bits for variant 1. A block never leaves its group of twelve.
- R11: With reordering off, the output is the tiled offset of R4 plus R5, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_x | input | X_W | Column in bytes |
| in_y | input | Y_W | Row |
| in_pitch | input | PITCH_W | Surface width in tiles |
| in_h_sel | input | 3 | Tile height select (R3) |
| in_reorder_flag | input | 1 | Page-attribute reorder bit (mask 0x0800) |
| in_variant | input | 1 | Reorder pattern select: 0 = 8 KiB, 1 = 16 KiB |
| out_valid | output | 1 | Result strobe |
| out_offset | output | OFF_W | Byte offset |

## Verification
On every cycle, the assertions check four things:
- the two-edge spacing between a request strobe and its result;
- that a result with reordering off equals the stage-one tiled offset;
- that reordering keeps the in-block low bits;
- that a reordered 8 KiB block stays inside its group of twelve.

The tiled arithmetic itself can only be shown by the directed scenarios. These cover the height decoding, the nested in-tile layout, and the exact block permutation of each pattern. The scenarios compare the design against a reference model written from R4, R5, R8 and R9.

// File: rtl/tam_pkg.sv
package tam_pkg;
  localparam int TILE_W_LOG2 = 6;
  localparam int INTRA_W     = 12;
  localparam int GROUP_LEN   = 12;
  localparam int BLK_SHIFT0  = 13;

  function automatic logic [2:0] height_log2(input logic [2:0] sel);
    return (sel > 3'd4) ? 3'd6 : 3'(sel + 3'd2);
  endfunction

  function automatic logic signed [3:0] block_shift(input logic variant, input logic [3:0] pos);
    logic signed [3:0] d;
    d = 4'sd0;
    if (!variant) begin
      case (pos)
        4'd0, 4'd2, 4'd4: d = 4'sd1;
        4'd1, 4'd3, 4'd5: d = -4'sd1;
        4'd6:             d = 4'sd2;
        4'd7:             d = 4'sd3;
        4'd8, 4'd11:      d = -4'sd2;
        4'd9:             d = 4'sd2;
        4'd10:            d = -4'sd3;
        default:          d = 4'sd0;
      endcase
    end else begin
      case (pos)
        4'd0, 4'd8, 4'd10: d = 4'sd1;
        4'd1, 4'd9, 4'd11: d = -4'sd1;
        4'd2, 4'd5:        d = 4'sd2;
        4'd3:              d = 4'sd3;
        4'd4, 4'd7:        d = -4'sd2;
        4'd6:              d = -4'sd3;
        default:           d = 4'sd0;
      endcase
    end
    return d;
  endfunction
endpackage

// File: rtl/tam_tile_base.sv
module tam_tile_base #(
  parameter int COL_W   = 10,
  parameter int Y_W     = 16,
  parameter int PITCH_W = 12,
  parameter int OFF_W   = 32
) (
  input  logic [COL_W-1:0]   col_tile,
  input  logic [Y_W-1:0]     y,
  input  logic [PITCH_W-1:0] pitch,
  input  logic [2:0]         h_log2,
  output logic [OFF_W-1:0]   base
);
  localparam int PROD_W = Y_W + PITCH_W + 1;

  logic [Y_W-1:0]    row_tile;
  logic [PROD_W-1:0] tile_idx;

  always_comb begin
    row_tile = y >> h_log2;
    tile_idx = PROD_W'(row_tile) * PROD_W'(pitch) + PROD_W'(col_tile);
    base     = OFF_W'(tile_idx) << (tam_pkg::TILE_W_LOG2 + int'(h_log2));
  end
endmodule

// File: rtl/tam_intra_map.sv
module tam_intra_map (
  input  logic [5:0]                     lx,
  input  logic [5:0]                     y_low,
  input  logic [2:0]                     h_log2,
  output logic [tam_pkg::INTRA_W-1:0]    intra
);
  logic [5:0] ly;
  logic [5:0] row_mask;

  always_comb begin
    row_mask = 6'((7'd1 << h_log2) - 7'd1);
    ly       = y_low & row_mask;
    // strip / quad / cell / byte nesting as interleaved coordinate bits
    intra = {ly[5:3], ly[2], lx[5], ly[1], lx[4:3], ly[0], lx[2:0]};
  end
endmodule

// File: rtl/tam_block_reorder.sv
module tam_block_reorder #(
  parameter int OFF_W = 32
) (
  input  logic [OFF_W-1:0] off_in,
  input  logic             enable,
  input  logic             variant,
  output logic [OFF_W-1:0] off_out
);
  logic [OFF_W-1:0] cand [2];

  for (genvar g = 0; g < 2; g++) begin : g_var
    localparam int SH = tam_pkg::BLK_SHIFT0 + g;
    localparam int BW = OFF_W - SH;
    logic [BW-1:0]     blk;
    logic [3:0]        pos;
    logic signed [3:0] delta;
    logic [BW-1:0]     new_blk;
    always_comb begin
      blk     = off_in[OFF_W-1:SH];
      pos     = 4'(blk % BW'(tam_pkg::GROUP_LEN));
      delta   = tam_pkg::block_shift(1'(g), pos);
      new_blk = blk + BW'(delta);
    end
    assign cand[g] = {new_blk, off_in[SH-1:0]};
  end

  assign off_out = enable ? cand[variant] : off_in;
endmodule

// File: rtl/tiled_addr_mapper.sv
module tiled_addr_mapper #(
  parameter int X_W     = 16,
  parameter int Y_W     = 16,
  parameter int PITCH_W = 12,
  parameter int OFF_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [X_W-1:0]     in_x,
  input  logic [Y_W-1:0]     in_y,
  input  logic [PITCH_W-1:0] in_pitch,
  input  logic [2:0]         in_h_sel,
  input  logic               in_reorder_flag,
  input  logic               in_variant,
  output logic               out_valid,
  output logic [OFF_W-1:0]   out_offset
);
  localparam int COL_W = X_W - tam_pkg::TILE_W_LOG2;

  logic [2:0]                  h_log2;
  logic [OFF_W-1:0]            tile_base;
  logic [tam_pkg::INTRA_W-1:0] intra;
  logic [OFF_W-1:0]            tiled_off;
  logic [OFF_W-1:0]            reord_off;

  logic             s1_valid;
  logic [OFF_W-1:0] s1_offset;
  logic             s1_reorder;
  logic             s1_variant;

  assign h_log2 = tam_pkg::height_log2(in_h_sel);

  tam_tile_base #(.COL_W(COL_W), .Y_W(Y_W), .PITCH_W(PITCH_W), .OFF_W(OFF_W)) u_base (
    .col_tile(in_x[X_W-1:tam_pkg::TILE_W_LOG2]),
    .y(in_y),
    .pitch(in_pitch),
    .h_log2(h_log2),
    .base(tile_base)
  );

  tam_intra_map u_intra (
    .lx(in_x[5:0]),
    .y_low(in_y[5:0]),
    .h_log2(h_log2),
    .intra(intra)
  );

  assign tiled_off = tile_base | OFF_W'(intra);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid   <= 1'b0;
      s1_offset  <= '0;
      s1_reorder <= 1'b0;
      s1_variant <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_offset  <= tiled_off;
        s1_reorder <= in_reorder_flag;
        s1_variant <= in_variant;
      end
    end
  end

  tam_block_reorder #(.OFF_W(OFF_W)) u_reorder (
    .off_in(s1_offset),
    .enable(s1_reorder),
    .variant(s1_variant),
    .off_out(reord_off)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_offset <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_offset <= reord_off;
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid);
  assert_no_phantom_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid);
  assert_bypass_R11: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_reorder) |=> out_offset == $past(s1_offset));
  assert_low_bits_R10: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_reorder) |=> out_offset[12:0] == $past(s1_offset[12:0]));
  assert_group_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_reorder && !s1_variant) |=>
      ((out_offset >> 13) / 12) == (($past(s1_offset) >> 13) / 12));
endmodule

// File: tb/tiled_addr_mapper_tb.sv
module tiled_addr_mapper_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_x = '0;
  logic [15:0] in_y = '0;
  logic [11:0] in_pitch = '0;
  logic [2:0]  in_h_sel = '0;
  logic        in_reorder_flag = 1'b0;
  logic        in_variant = 1'b0;
  logic        out_valid;
  logic [31:0] out_offset;

  int checks = 0;
  int failures = 0;
  int pa [12] = '{1, -1, 1, -1, 1, -1, 2, 3, -2, 2, -3, -2};
  int pb [12] = '{1, -1, 2, 3, -2, 2, -3, -2, 1, -1, 1, -1};

  always #10 clk = ~clk;

  tiled_addr_mapper u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .in_pitch(in_pitch), .in_h_sel(in_h_sel), .in_reorder_flag(in_reorder_flag),
    .in_variant(in_variant), .out_valid(out_valid), .out_offset(out_offset)
  );

  function automatic longint ref_off(int x, int y, int pitch, int sel, bit ro, bit v);
    longint h, ly, lx, r8, r4, x32, off, bs, b, nb;
    h   = (sel >= 4) ? 64 : (4 << sel);
    lx  = x % 64;
    ly  = y % h;
    r8  = ly % 8;
    r4  = r8 % 4;
    x32 = lx % 32;
    off = ((y / h) * pitch + x / 64) * 64 * h
        + (ly / 8) * 512 + ((r8 / 4) * 2 + lx / 32) * 128
        + ((r4 / 2) * 4 + x32 / 8) * 16 + (r4 % 2) * 8 + x32 % 8;
    off = off & 64'hFFFF_FFFF;
    if (ro) begin
      bs  = v ? 16384 : 8192;
      b   = off / bs;
      nb  = b + (v ? pb[b % 12] : pa[b % 12]);
      off = (nb * bs + off % bs) & 64'hFFFF_FFFF;
    end
    return off;
  endfunction

  task automatic check(bit cond, string req, longint act, longint exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_in(int x, int y, int pitch, int sel, bit ro, bit v, bit val);
    in_x = 16'(x); in_y = 16'(y); in_pitch = 12'(pitch); in_h_sel = 3'(sel);
    in_reorder_flag = ro; in_variant = v; in_valid = val;
  endtask

  task automatic one(int x, int y, int pitch, int sel, bit ro, bit v, string req);
    longint e;
    e = ref_off(x, y, pitch, sel, ro, v);
    @(negedge clk); set_in(x, y, pitch, sel, ro, v, 1'b1);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b1, req, longint'(out_valid), 1);
    check(longint'(out_offset) == e, req, longint'(out_offset), e);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", longint'(out_valid), 0);
    check(out_offset == 32'd0, "R1", longint'(out_offset), 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_offset == 32'd0, "R1", longint'(out_offset), 0);
  endtask

  task automatic t_latency;
    @(negedge clk); set_in(100, 20, 3, 2, 1'b0, 1'b0, 1'b1);
    @(negedge clk); in_valid = 1'b0;
    check(out_valid == 1'b0, "R2 early", longint'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R2 on time", longint'(out_valid), 1);
    @(negedge clk);
    check(out_valid == 1'b0, "R2 single", longint'(out_valid), 0);
  endtask

  task automatic t_stream;
    int xs [4] = '{5, 70, 130, 255};
    int ys [4] = '{1, 9, 33, 100};
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        longint e;
        e = ref_off(xs[i-2], ys[i-2], 4, 3, 1'b0, 1'b0);
        check(out_valid == 1'b1, "R2 stream", longint'(out_valid), 1);
        check(longint'(out_offset) == e, "R2 stream", longint'(out_offset), e);
      end
      if (i < 4) set_in(xs[i], ys[i], 4, 3, 1'b0, 1'b0, 1'b1);
      else in_valid = 1'b0;
    end
  endtask

  task automatic t_heights;
    for (int s = 0; s < 8; s++) one(200, 77, 5, s, 1'b0, 1'b0, "R3 R4");
    one(0, 0, 7, 1, 1'b0, 1'b0, "R4 origin");
    one(64, 8, 7, 1, 1'b0, 1'b0, "R4 next tile");
  endtask

  task automatic t_intra;
    int xs [7] = '{0, 7, 8, 63, 32, 5, 41};
    int ys [7] = '{0, 1, 0, 7, 4, 63, 22};
    for (int i = 0; i < 7; i++) one(xs[i], ys[i], 2, 4, 1'b0, 1'b0, "R5");
    one(40, 3, 1, 0, 1'b0, 1'b0, "R6 quad");
    one(0, 4, 1, 0, 1'b0, 1'b0, "R6 next row");
    one(63, 2, 1, 0, 1'b0, 1'b0, "R6 corner");
  endtask

  task automatic t_reorder_a;
    for (int k = 0; k < 14; k++) one(9, k * 128 + 1, 1, 0, 1'b1, 1'b0, "R8 R10");
  endtask

  task automatic t_reorder_b;
    for (int k = 0; k < 13; k++) one(17, k * 256 + 2, 1, 0, 1'b1, 1'b1, "R9 R10");
  endtask

  task automatic t_flag_off;
    one(9, 6 * 128 + 1, 1, 0, 1'b0, 1'b0, "R7 R11 v0");
    one(17, 3 * 256 + 2, 1, 0, 1'b0, 1'b1, "R7 R11 v1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_stream();
    t_heights();
    t_intra();
    t_reorder_a();
    t_reorder_b();
    t_flag_off();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule